// File: doc/BRIEF.md
# Bus-Master DMA Register Window

This block decodes a 16-byte I/O window serving two DMA channels. Each channel owns an 8-byte slot. The low four bytes of a slot are byte-wide control registers: command, the shared mode byte, status and the channel's timing byte. The upper four bytes hold a 32-bit descriptor table address.

The block holds the command, status, timing and descriptor address registers itself. The mode byte belongs to the interrupt logic. This window reads the mode byte through an input. A write to it is passed back as a strobe carrying the merged value, so the interrupt logic can store it, re-synchronise its mirrored flags and re-evaluate its interrupt output.

A command write stores the byte and sends a one-cycle strobe to the DMA engine. The engine reports its active level and error and interrupt events into the status register. Reads are combinational from the address and access size.

Top module: `bmwin_top`

## Requirements
- R1: After reset, every register held in the window reads zero and no strobe is asserted.
- R2: A byte write to the command offset (0 in a slot) stores wrData[7:0]. In the next cycle, that channel's bit of cmdStb is high for exactly one cycle and cmdByte shows the value.
- R3: A byte write to status (offset 2) gives a new value built as follows. Bits 6:5 are taken from the written data. Bit 0 is kept. Bits 2:1 are cleared where the written data has ones and kept elsewhere. Bits 7 and 4:3 read zero.
- R4: Status bit 0 follows the channel's engActive from the previous cycle. Bit 1 is set by an engErr pulse and bit 2 by an engIrq pulse. A pulse wins over a same-cycle write-one-to-clear.
- R5: Offset 1 of either slot reads modeIn. A byte write there pulses modeWrStb in the same cycle, with modeWrData equal to modeIn in every bit except bits 5:4, which come from the write.
- R6: Offset 3 reads and writes a timing byte that belongs to the channel of the slot. It is shown on timingByte, channel 0 in bits 7:0.
- R7: A control offset (0 to 3) accessed with accSize other than byte (0 byte, 1 half, 2 word) reads all ones for the access width: 0xFF, 0xFFFF or 0xFFFFFFFF. A write of that kind changes nothing.
- R8: A word write to offset 4 of a slot stores the descriptor address. The address reads back, and drives descAddr, with bits 1:0 forced to zero. Non-word accesses there read all ones and do not write.
- R9: Offsets 5 to 7 of each slot read all ones for the access width, and writes there change nothing.
- R10: Address bit 3 selects the channel: addresses 0 to 7 reach channel 0 and 8 to 15 reach channel 1. The two channels' registers are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write enable for the current access |
| addr | input | 4 | Byte offset inside the window |
| accSize | input | 2 | Access width: 0 byte, 1 half, 2 word |
| wrData | input | 32 | Write data, byte accesses use bits 7:0 |
| rdData | output | 32 | Combinational read data |
| modeIn | input | 8 | Current shared mode byte from the interrupt logic |
| modeWrStb | output | 1 | Mode byte write request |
| modeWrData | output | 8 | Merged mode byte to store |
| engActive | input | 2 | Per-channel engine active level |
| engErr | input | 2 | Per-channel engine error pulse |
| engIrq | input | 2 | Per-channel engine interrupt pulse |
| cmdStb | output | 2 | Per-channel command-written strobe |
| cmdByte | output | 16 | Command registers, channel 0 in bits 7:0 |
| timingByte | output | 16 | Timing registers, channel 0 in bits 7:0 |
| descAddr | output | 64 | Descriptor addresses, channel 0 in bits 31:0 |

## Verification
The bench builds the block with the package defaults: two channels, 8-byte slots and 32-bit descriptor addresses. This places every offset of both slots, including the unmapped tail of each, inside the 4-bit window address, so every decode outcome is reached. Engine pulses are lined up with status writes in the same cycle to reach the set-over-clear case. Both channels are written with different values to expose any cross-channel aliasing.

// File: rtl/bmwin_pkg.sv
package bmwin_pkg;
  localparam int BM_CH = 2;
  localparam int BM_SLOT_BITS = 3;
  localparam int BM_DESC_W = 32;
  localparam int BM_CH_IDX_W = (BM_CH > 1) ? $clog2(BM_CH) : 1;
  localparam int BM_WIN_AW = $clog2(BM_CH) + BM_SLOT_BITS;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam int ST_ACT = 0;
  localparam int ST_ERR = 1;
  localparam int ST_IRQ = 2;
  localparam logic [7:0] ST_WRITE_MASK = 8'h60;
  localparam logic [7:0] ST_W1C_MASK = 8'h06;
  localparam logic [7:0] MODE_WIN_MASK = 8'h30;

  typedef enum logic [2:0] {
    SEL_ONES, SEL_CMD, SEL_MODE, SEL_STAT, SEL_TIM, SEL_DESC
  } rdSel_e;

  typedef struct packed {
    logic [BM_CH-1:0] cmdWr;
    logic [BM_CH-1:0] statWr;
    logic [BM_CH-1:0] timWr;
    logic [BM_CH-1:0] descWr;
    logic             modeWr;
  } wrStb_t;
endpackage

// File: rtl/bmwin_ctrl.sv
module bmwin_ctrl
  import bmwin_pkg::*;
(
  input  logic                   wrEn,
  input  logic [BM_WIN_AW-1:0]   addr,
  input  logic [1:0]             accSize,
  output wrStb_t                 stb,
  output rdSel_e                 rdSel,
  output logic [BM_CH_IDX_W-1:0] chSel
);
  logic [BM_SLOT_BITS-1:0] off;
  logic isByte;
  logic isWord;

  assign off    = addr[BM_SLOT_BITS-1:0];
  assign isByte = (accSize == SZ_BYTE);
  assign isWord = (accSize == SZ_WORD);

  always_comb begin
    chSel = '0;
    chSel = addr[BM_WIN_AW-1:BM_SLOT_BITS];
  end

  // Slot layout: control bytes in the low half, descriptor word at the half boundary
  always_comb begin
    rdSel = SEL_ONES;
    if (!off[BM_SLOT_BITS-1]) begin
      if (isByte) begin
        unique case (off[1:0])
          2'd0: rdSel = SEL_CMD;
          2'd1: rdSel = SEL_MODE;
          2'd2: rdSel = SEL_STAT;
          default: rdSel = SEL_TIM;
        endcase
      end
    end else if (off[BM_SLOT_BITS-2:0] == '0 && isWord) begin
      rdSel = SEL_DESC;
    end
  end

  always_comb begin
    stb = '0;
    if (wrEn) begin
      unique case (rdSel)
        SEL_CMD:  stb.cmdWr[chSel]  = 1'b1;
        SEL_MODE: stb.modeWr        = 1'b1;
        SEL_STAT: stb.statWr[chSel] = 1'b1;
        SEL_TIM:  stb.timWr[chSel]  = 1'b1;
        SEL_DESC: stb.descWr[chSel] = 1'b1;
        default:  stb = '0;
      endcase
    end
  end
endmodule

// File: rtl/bmwin_datapath.sv
module bmwin_datapath
  import bmwin_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  wrStb_t                   stb,
  input  rdSel_e                   rdSel,
  input  logic [BM_CH_IDX_W-1:0]   chSel,
  input  logic [1:0]               accSize,
  input  logic [31:0]              wrData,
  input  logic [7:0]               modeIn,
  input  logic [BM_CH-1:0]         engActive,
  input  logic [BM_CH-1:0]         engErr,
  input  logic [BM_CH-1:0]         engIrq,
  output logic [31:0]              rdData,
  output logic                     modeWrStb,
  output logic [7:0]               modeWrData,
  output logic [BM_CH-1:0]         cmdStb,
  output logic [BM_CH*8-1:0]       cmdByte,
  output logic [BM_CH*8-1:0]       timingByte,
  output logic [BM_CH*BM_DESC_W-1:0] descAddr
);
  logic [BM_CH*8-1:0] statFlat;

  for (genvar g = 0; g < BM_CH; g++) begin : g_ch
    logic [7:0] cmdR;
    logic [7:0] statR;
    logic [7:0] timR;
    logic [BM_DESC_W-1:0] descR;
    logic strobeR;
    logic [7:0] statNext;

    always_comb begin
      if (stb.statWr[g]) begin
        statNext = (wrData[7:0] & ST_WRITE_MASK)
                 | (statR & ~wrData[7:0] & ST_W1C_MASK);
      end else begin
        statNext = statR & (ST_WRITE_MASK | ST_W1C_MASK);
      end
      statNext[ST_ACT] = engActive[g];
      statNext[ST_ERR] = statNext[ST_ERR] | engErr[g];
      statNext[ST_IRQ] = statNext[ST_IRQ] | engIrq[g];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmdR    <= '0;
        statR   <= '0;
        timR    <= '0;
        descR   <= '0;
        strobeR <= 1'b0;
      end else begin
        strobeR <= stb.cmdWr[g];
        statR   <= statNext;
        if (stb.cmdWr[g]) cmdR <= wrData[7:0];
        if (stb.timWr[g]) timR <= wrData[7:0];
        if (stb.descWr[g]) descR <= {wrData[BM_DESC_W-1:2], 2'b00};
      end
    end

    assign cmdStb[g]                        = strobeR;
    assign cmdByte[g*8 +: 8]                = cmdR;
    assign timingByte[g*8 +: 8]             = timR;
    assign statFlat[g*8 +: 8]               = statR;
    assign descAddr[g*BM_DESC_W +: BM_DESC_W] = descR;
  end

  assign modeWrStb  = stb.modeWr;
  assign modeWrData = (modeIn & ~MODE_WIN_MASK) | (wrData[7:0] & MODE_WIN_MASK);

  logic [31:0] onesVal;
  always_comb begin
    unique case (accSize)
      SZ_BYTE: onesVal = 32'h0000_00FF;
      SZ_HALF: onesVal = 32'h0000_FFFF;
      default: onesVal = 32'hFFFF_FFFF;
    endcase
  end

  always_comb begin
    int idx;
    idx = int'(chSel);
    unique case (rdSel)
      SEL_CMD:  rdData = {24'd0, cmdByte[idx*8 +: 8]};
      SEL_MODE: rdData = {24'd0, modeIn};
      SEL_STAT: rdData = {24'd0, statFlat[idx*8 +: 8]};
      SEL_TIM:  rdData = {24'd0, timingByte[idx*8 +: 8]};
      SEL_DESC: rdData = descAddr[idx*BM_DESC_W +: 32];
      default:  rdData = onesVal;
    endcase
  end
endmodule

// File: rtl/bmwin_top.sv
module bmwin_top
  import bmwin_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  addr,
  input  logic [1:0]  accSize,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic [7:0]  modeIn,
  output logic        modeWrStb,
  output logic [7:0]  modeWrData,
  input  logic [1:0]  engActive,
  input  logic [1:0]  engErr,
  input  logic [1:0]  engIrq,
  output logic [1:0]  cmdStb,
  output logic [15:0] cmdByte,
  output logic [15:0] timingByte,
  output logic [63:0] descAddr
);
  wrStb_t stb;
  rdSel_e rdSel;
  logic [BM_CH_IDX_W-1:0] chSel;

  bmwin_ctrl u_ctrl (
    .wrEn    (wrEn),
    .addr    (addr),
    .accSize (accSize),
    .stb     (stb),
    .rdSel   (rdSel),
    .chSel   (chSel)
  );

  bmwin_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .rdSel      (rdSel),
    .chSel      (chSel),
    .accSize    (accSize),
    .wrData     (wrData),
    .modeIn     (modeIn),
    .engActive  (engActive),
    .engErr     (engErr),
    .engIrq     (engIrq),
    .rdData     (rdData),
    .modeWrStb  (modeWrStb),
    .modeWrData (modeWrData),
    .cmdStb     (cmdStb),
    .cmdByte    (cmdByte),
    .timingByte (timingByte),
    .descAddr   (descAddr)
  );
endmodule

// File: rtl/bmwin_checker.sv
module bmwin_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [3:0]  addr,
  input logic [1:0]  accSize,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic [7:0]  modeIn,
  input logic        modeWrStb,
  input logic [7:0]  modeWrData,
  input logic [1:0]  engActive,
  input logic [1:0]  engErr,
  input logic [1:0]  engIrq,
  input logic [1:0]  cmdStb,
  input logic [15:0] cmdByte,
  input logic [15:0] timingByte,
  input logic [63:0] descAddr
);
  p_cmd_stb0_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdStb[0] |-> $past(wrEn && addr == 4'd0 && accSize == 2'd0));

  p_cmd_stb1_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdStb[1] |-> $past(wrEn && addr == 4'd8 && accSize == 2'd0));

  p_mode_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    modeWrStb |-> (((modeWrData ^ modeIn) & 8'hCF) == 8'h00
                   && modeWrData[5:4] == wrData[5:4]));

  p_stat_rsvd_r3: assert property (@(posedge clk) disable iff (!rstN)
    (addr[2:0] == 3'd2 && accSize == 2'd0) |->
      (rdData[31:7] == 25'd0 && rdData[4:3] == 2'd0));

  p_stat_act_r4: assert property (@(posedge clk) disable iff (!rstN)
    (addr[2:0] == 3'd2 && accSize == 2'd0) |->
      rdData[0] == (addr[3] ? $past(engActive[1]) : $past(engActive[0])));

  p_wide_ones_r7: assert property (@(posedge clk) disable iff (!rstN)
    (addr[2] == 1'b0 && accSize == 2'd1) |-> rdData == 32'h0000_FFFF);

  p_desc_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (addr[2:0] == 3'd4 && accSize == 2'd2) |-> rdData[1:0] == 2'b00);

  p_desc_align_r8: assert property (@(posedge clk) disable iff (!rstN)
    descAddr[1:0] == 2'b00 && descAddr[33:32] == 2'b00);
endmodule

bind bmwin_top bmwin_checker chk (.*);

// File: tb/tb_bmwin_top.sv
`timescale 1ns/1ps
module tb_bmwin_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  accSize = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [7:0]  modeIn = '0;
  logic        modeWrStb;
  logic [7:0]  modeWrData;
  logic [1:0]  engActive = '0;
  logic [1:0]  engErr = '0;
  logic [1:0]  engIrq = '0;
  logic [1:0]  cmdStb;
  logic [15:0] cmdByte;
  logic [15:0] timingByte;
  logic [63:0] descAddr;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  bmwin_top dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    addr = a; accSize = sz; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    addr = a; accSize = sz;
    #1 d = rdData;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 cmdStb", cmdStb, 0);
    check("R1 modeWrStb", modeWrStb, 0);
    busRead(4'd0, 2'd0, v);  check("R1 cmd0", v, 0);
    busRead(4'd2, 2'd0, v);  check("R1 stat0", v, 0);
    busRead(4'd11, 2'd0, v); check("R1 tim1", v, 0);
    busRead(4'd12, 2'd2, v); check("R1 desc1", v, 0);
  endtask

  task automatic t_cmd();
    logic [31:0] v;
    busWrite(4'd0, 2'd0, 32'h0000_0009);
    check("R2 strobe ch0", cmdStb, 2'b01);
    check("R2 cmdByte", cmdByte[7:0], 8'h09);
    @(negedge clk);
    check("R2 strobe one cycle", cmdStb, 2'b00);
    busRead(4'd0, 2'd0, v); check("R2 readback", v, 32'h09);
    busWrite(4'd8, 2'd0, 32'h0000_0001);
    check("R10 strobe ch1", cmdStb, 2'b10);
    check("R10 cmd ch1 value", cmdByte, 16'h0109);
  endtask

  task automatic t_status();
    logic [31:0] v;
    @(negedge clk); engActive = 2'b01; engErr = 2'b01; engIrq = 2'b01;
    @(negedge clk); engErr = 2'b00; engIrq = 2'b00;
    busRead(4'd2, 2'd0, v);  check("R4 pulses set", v, 32'h07);
    busRead(4'd10, 2'd0, v); check("R10 ch1 status untouched", v, 32'h00);
    busWrite(4'd2, 2'd0, 32'h02);
    busRead(4'd2, 2'd0, v);  check("R3 w1c bit1 only", v, 32'h05);
    busWrite(4'd2, 2'd0, 32'hFF);
    busRead(4'd2, 2'd0, v);  check("R3 merge ff", v, 32'h61);
    busWrite(4'd2, 2'd0, 32'h00);
    busRead(4'd2, 2'd0, v);  check("R3 merge 00", v, 32'h01);
    @(negedge clk);
    addr = 4'd2; accSize = 2'd0; wrData = 32'h04; wrEn = 1'b1; engIrq = 2'b01;
    @(negedge clk);
    wrEn = 1'b0; engIrq = 2'b00;
    busRead(4'd2, 2'd0, v);  check("R4 set wins", v, 32'h05);
    engActive = 2'b00;
    busRead(4'd2, 2'd0, v);
    busRead(4'd2, 2'd0, v);  check("R4 active follows", v, 32'h04);
  endtask

  task automatic t_mode();
    logic [31:0] v;
    modeIn = 8'hCC;
    busRead(4'd1, 2'd0, v); check("R5 read mode", v, 32'hCC);
    @(negedge clk);
    addr = 4'd9; accSize = 2'd0; wrData = 32'hFF; wrEn = 1'b1;
    #1 check("R5 strobe", modeWrStb, 1);
    check("R5 merged ff", modeWrData, 8'hFC);
    @(negedge clk);
    wrData = 32'h00;
    #1 check("R5 merged 00", modeWrData, 8'hCC);
    @(negedge clk);
    wrEn = 1'b0;
    #1 check("R5 strobe idle", modeWrStb, 0);
  endtask

  task automatic t_timing();
    logic [31:0] v;
    busWrite(4'd3, 2'd0, 32'hA5);
    busWrite(4'd11, 2'd0, 32'h5A);
    busRead(4'd3, 2'd0, v);  check("R6 tim0", v, 32'hA5);
    busRead(4'd11, 2'd0, v); check("R10 tim1", v, 32'h5A);
    check("R6 timingByte", timingByte, 16'h5AA5);
  endtask

  task automatic t_wide();
    logic [31:0] v;
    busRead(4'd0, 2'd1, v); check("R7 half ones", v, 32'h0000_FFFF);
    busRead(4'd2, 2'd2, v); check("R7 word ones", v, 32'hFFFF_FFFF);
    busWrite(4'd0, 2'd2, 32'h77);
    check("R7 no strobe", cmdStb, 2'b00);
    check("R7 cmd kept", cmdByte, 16'h0109);
    busWrite(4'd3, 2'd1, 32'h33);
    check("R7 timing kept", timingByte, 16'h5AA5);
  endtask

  task automatic t_desc();
    logic [31:0] v;
    busWrite(4'd4, 2'd2, 32'h1234_5677);
    busRead(4'd4, 2'd2, v);  check("R8 desc0", v, 32'h1234_5674);
    busWrite(4'd12, 2'd2, 32'hDEAD_BEEF);
    busRead(4'd12, 2'd2, v); check("R10 desc1", v, 32'hDEAD_BEEC);
    check("R8 descAddr", descAddr, 64'hDEAD_BEEC_1234_5674);
    busWrite(4'd4, 2'd0, 32'h0000_0000);
    busRead(4'd4, 2'd2, v);  check("R8 byte write ignored", v, 32'h1234_5674);
    busRead(4'd4, 2'd0, v);  check("R8 byte read ones", v, 32'hFF);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    busRead(4'd5, 2'd0, v);  check("R9 off5", v, 32'hFF);
    busRead(4'd15, 2'd1, v); check("R9 off15", v, 32'hFFFF);
    busRead(4'd7, 2'd2, v);  check("R9 off7", v, 32'hFFFF_FFFF);
    busWrite(4'd6, 2'd2, 32'h0);
    busWrite(4'd13, 2'd0, 32'h0);
    check("R9 desc kept", descAddr, 64'hDEAD_BEEC_1234_5674);
    check("R9 cmd kept", cmdByte, 16'h0109);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_cmd();
    t_status();
    t_mode();
    t_timing();
    t_wide();
    t_desc();
    t_unmapped();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule